// File: doc/BRIEF.md
# Bus Passive-Period Symbol Detector

This block watches the passive/active level of a single-wire vehicle bus and measures how long the bus has been passive since it last saw activity. A prescaler turns the system clock into a one-microsecond tick. The measurement is a single saturating microsecond counter. As that counter grows, the passive interval first becomes an end-of-data event, then an end-of-frame event, and at last a bus-idle state.

The end-of-data and end-of-frame events each appear as a one-cycle pulse. End-of-frame also sets a sticky flag that software clears with a write-one-to-clear strobe. The bus-idle output tells a local transmitter that the interframe separation has also elapsed, so it may start a new frame. Any active level restarts the measurement and cancels whatever promotion was pending. The block does not decode active symbols, data bits, arbitration or the CRC.

Top module: `bus_gap_detector`

## Requirements
- R1: While rst_ni is low, eod_pulse_o, eof_pulse_o, eof_flag_o and bus_idle_o are all 0.
- R2: bus_active_i (1 = active, 0 = passive) passes through two synchronizer flops. eod_pulse_o is high for exactly one cycle once the synchronized level has been passive for EOD_US*CLK_PER_US consecutive clocks after activity. It appears two clocks later than that count measured at the input pin.
- R3: eof_pulse_o is high for exactly one cycle once the same passive interval reaches EOF_US*CLK_PER_US clocks. If no activity intervenes, the interval that produced the end-of-data pulse goes on to produce this pulse.
- R4: In any one passive interval, eod_pulse_o fires at most once and eof_pulse_o fires at most once, and never in the same cycle as each other.
- R5: eof_flag_o rises in the same cycle as eof_pulse_o. It stays at 1 until a cycle in which eof_clr_i is 1 and no new end-of-frame occurs. If both happen in the same cycle, the set wins. eof_clr_i has no effect while the flag is 0.
- R6: An end-of-data event leaves eof_flag_o unchanged.
- R7: bus_idle_o goes to 1 once the synchronized level has been passive for IDLE_US*CLK_PER_US consecutive clocks. It stays at 1 until the synchronized level is active again.
- R8: Any synchronized active level, even a single clock long, restarts the measurement at zero. It also cancels any pending end-of-data, end-of-frame or idle promotion.
- R9: Out of reset, bus_idle_o rises only after a full IDLE_US*CLK_PER_US clocks of passive level have been observed from reset release. No end-of-data or end-of-frame pulse fires until some activity has been seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_active_i | input | 1 | Raw bus level, 1 = active, 0 = passive |
| eof_clr_i | input | 1 | Write-one-to-clear strobe for the end-of-frame flag |
| eod_pulse_o | output | 1 | One-cycle end-of-data event |
| eof_pulse_o | output | 1 | One-cycle end-of-frame event |
| eof_flag_o | output | 1 | Sticky end-of-frame flag |
| bus_idle_o | output | 1 | Bus free for a new frame |

## Verification
The bound checker checks the cycle-level rules on every clock:
- both pulses last a single cycle and never coincide;
- the flag rises only with an end-of-frame pulse and falls only after a clear strobe;
- a synchronized active level removes idle and suppresses both pulses on the next clock;
- nothing fires before the first activity after reset.

The exact cycle on which each threshold is crossed can only be shown by the bench's scenarios. The same goes for the two-clock synchronizer latency, the cancellation of a half-finished interval by a short glitch, and the race between a clear strobe and a new end-of-frame. The bench covers these with directed runs and random active/passive patterns, compared cycle by cycle with a model built from the requirements.

// File: rtl/gap_pkg.sv
package gap_pkg;
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gap_sync.sv
module gap_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= 2'b00;
    else         ff_q <= {ff_q[0], d_i};
  end
  assign q_o = ff_q[1];
endmodule

// File: rtl/gap_prescaler.sv
module gap_prescaler #(
  parameter int CLK_PER_US = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic tick_o
);
  localparam int PS_W = gap_pkg::cnt_w(CLK_PER_US);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_US - 1);

  logic [PS_W-1:0] ps_q;

  // restart phase on activity so the first microsecond is a full one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ps_q <= '0;
    else if (act_i)           ps_q <= '0;
    else if (ps_q == PS_LAST) ps_q <= '0;
    else                      ps_q <= ps_q + 1'b1;
  end

  assign tick_o = !act_i && (ps_q == PS_LAST);
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int EOD_US  = 200,
  parameter int EOF_US  = 280,
  parameter int IDLE_US = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic tick_i,
  input  logic eof_clr_i,
  output logic eod_o,
  output logic eof_o,
  output logic flag_o,
  output logic idle_o,
  output logic armed_o
);
  localparam int US_W = $clog2(IDLE_US + 1);
  localparam logic [US_W-1:0] EOD_M1  = US_W'(EOD_US - 1);
  localparam logic [US_W-1:0] EOF_M1  = US_W'(EOF_US - 1);
  localparam logic [US_W-1:0] IDLE_L  = US_W'(IDLE_US);

  logic [US_W-1:0] us_q;
  logic armed_q, eod_q, eof_q, flag_q;
  logic hit_eod, hit_eof;

  assign hit_eod = tick_i && armed_q && (us_q == EOD_M1);
  assign hit_eof = tick_i && armed_q && (us_q == EOF_M1);

  // saturating passive-time counter, cleared by any activity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q    <= '0;
      armed_q <= 1'b0;
    end else if (act_i) begin
      us_q    <= '0;
      armed_q <= 1'b1;
    end else if (tick_i && us_q != IDLE_L) begin
      us_q    <= us_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eod_q  <= 1'b0;
      eof_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      eod_q <= hit_eod;
      eof_q <= hit_eof;
      if (hit_eof)        flag_q <= 1'b1;
      else if (eof_clr_i) flag_q <= 1'b0;
    end
  end

  assign eod_o   = eod_q;
  assign eof_o   = eof_q;
  assign flag_o  = flag_q;
  assign idle_o  = (us_q == IDLE_L);
  assign armed_o = armed_q;
endmodule

// File: rtl/bus_gap_detector.sv
module bus_gap_detector #(
  parameter int CLK_PER_US = 8,
  parameter int EOD_US     = 200,
  parameter int EOF_US     = 280,
  parameter int IDLE_US    = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_active_i,
  input  logic eof_clr_i,
  output logic eod_pulse_o,
  output logic eof_pulse_o,
  output logic eof_flag_o,
  output logic bus_idle_o
);
  logic act_s;
  logic us_tick;
  logic armed;

  gap_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bus_active_i),
    .q_o    (act_s)
  );

  gap_prescaler #(.CLK_PER_US(CLK_PER_US)) u_pres (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act_s),
    .tick_o (us_tick)
  );

  gap_timer #(.EOD_US(EOD_US), .EOF_US(EOF_US), .IDLE_US(IDLE_US)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act_s),
    .tick_i    (us_tick),
    .eof_clr_i (eof_clr_i),
    .eod_o     (eod_pulse_o),
    .eof_o     (eof_pulse_o),
    .flag_o    (eof_flag_o),
    .idle_o    (bus_idle_o),
    .armed_o   (armed)
  );
endmodule

// File: rtl/gap_detector_chk.sv
module gap_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic act_s,
  input logic armed,
  input logic eof_clr_i,
  input logic eod_pulse_o,
  input logic eof_pulse_o,
  input logic eof_flag_o,
  input logic bus_idle_o
);
  // R2
  eod_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eod_pulse_o |=> !eod_pulse_o);
  // R3
  eof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_pulse_o |=> !eof_pulse_o);
  // R4
  pulse_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eod_pulse_o && eof_pulse_o));
  // R5
  flag_with_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_pulse_o |-> eof_flag_o);
  // R5
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eof_flag_o) |-> $past(eof_clr_i));
  // R6
  flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eof_flag_o) |-> eof_pulse_o);
  // R7
  idle_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_s |=> !bus_idle_o);
  // R8
  act_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_s |=> !eod_pulse_o && !eof_pulse_o);
  // R9
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !eod_pulse_o && !eof_pulse_o && !eof_flag_o);
endmodule

bind bus_gap_detector gap_detector_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .act_s       (act_s),
  .armed       (armed),
  .eof_clr_i   (eof_clr_i),
  .eod_pulse_o (eod_pulse_o),
  .eof_pulse_o (eof_pulse_o),
  .eof_flag_o  (eof_flag_o),
  .bus_idle_o  (bus_idle_o)
);

// File: tb/bus_gap_detector_test.sv
module bus_gap_detector_test;
  localparam int N    = 4;
  localparam int EOD  = 200;
  localparam int EOF  = 280;
  localparam int IDL  = 300;
  localparam int EODC = EOD * N;
  localparam int EOFC = EOF * N;
  localparam int IDLC = IDL * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus = 1'b0;
  logic clr = 1'b0;
  logic eod, eof, flag, idle;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bus_gap_detector #(.CLK_PER_US(N), .EOD_US(EOD), .EOF_US(EOF), .IDLE_US(IDL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_active_i(bus), .eof_clr_i(clr),
    .eod_pulse_o(eod), .eof_pulse_o(eof), .eof_flag_o(flag), .bus_idle_o(idle)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  bit d1, d2, m_armed, m_eod, m_eof, m_flag, m_idle;
  int run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 = 0; d2 = 0; m_armed = 0; run = 0;
      m_eod = 0; m_eof = 0; m_flag = 0; m_idle = 0;
    end else begin
      if (d2) begin run = 0; m_armed = 1; end
      else if (run < IDLC + 10) run++;
      m_eod  = m_armed && !d2 && run == EODC;
      m_eof  = m_armed && !d2 && run == EOFC;
      m_idle = run >= IDLC;
      if (m_eof) m_flag = 1;
      else if (clr) m_flag = 0;
      d2 = d1;
      d1 = bus;
    end
  end

  int eod_seen = 0, eof_seen = 0;
  bit prev_flag = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(eod == m_eod, "R2", eod, m_eod);
      chk(eof == m_eof, "R3", eof, m_eof);
      chk(flag == m_flag, "R5", flag, m_flag);
      chk(idle == m_idle, "R7", idle, m_idle);
      if (eod) begin
        eod_seen++;
        chk(flag == prev_flag, "R6", flag, prev_flag);
      end
      if (eof) eof_seen++;
      prev_flag = flag;
    end
  end

  task automatic cyc(input bit b, input int n, input bit c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus = b;
      clr = c;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int e0, f0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk({eod, eof, flag, idle} == 4'b0, "R1", {eod, eof, flag, idle}, 0);
    rst_n = 1'b1;

    // from reset: passive only, idle after full window, no pulses
    cyc(0, IDLC - 2, 0);
    chk(idle == 0, "R9", idle, 0);
    cyc(0, 12, 0);
    chk(idle == 1, "R9", idle, 1);
    chk(eod_seen == 0 && eof_seen == 0, "R9", eod_seen + eof_seen, 0);

    // full frame gap: one EOD then one EOF
    cyc(1, 5, 0);
    cyc(0, IDLC + 30, 0);
    chk(eod_seen == 1, "R4", eod_seen, 1);
    chk(eof_seen == 1, "R4", eof_seen, 1);
    chk(flag == 1, "R5", flag, 1);
    cyc(0, 1, 1);
    cyc(0, 2, 0);
    chk(flag == 0, "R5", flag, 0);
    cyc(0, 1, 1);
    cyc(0, 2, 0);
    chk(flag == 0, "R5", flag, 0);

    // one-cycle glitch just before EOD restarts the measurement
    e0 = eod_seen; f0 = eof_seen;
    cyc(1, 3, 0);
    cyc(0, EODC - 2, 0);
    cyc(1, 1, 0);
    cyc(0, EODC - 5, 0);
    chk(eod_seen == e0, "R8", eod_seen, e0);
    cyc(0, IDLC, 0);
    chk(eod_seen == e0 + 1, "R8", eod_seen, e0 + 1);
    chk(eof_seen == f0 + 1, "R8", eof_seen, f0 + 1);

    // EOD reached, then activity before EOF
    e0 = eod_seen; f0 = eof_seen;
    cyc(1, 2, 0);
    cyc(0, EODC + 10, 0);
    cyc(1, 4, 0);
    chk(eod_seen == e0 + 1 && eof_seen == f0, "R3", eof_seen, f0);
    chk(idle == 0, "R7", idle, 0);

    // random active/passive patterns with random clears
    for (int it = 0; it < 45; it++) begin
      int plen;
      cyc(1, 1 + $urandom_range(0, 20), 0);
      case ($urandom_range(0, 3))
        0: plen = $urandom_range(1, EODC + 20);
        1: plen = $urandom_range(EODC - 4, EOFC + 8);
        default: plen = $urandom_range(EOFC - 4, IDLC + 60);
      endcase
      for (int k = 0; k < plen; k++) cyc(0, 1, ($urandom_range(0, 60) == 0));
    end
    cyc(0, IDLC + 10, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule